// File: doc/BRIEF.md
# Display Adapter Port Register File

This block is the byte-wide register file behind a legacy display adapter's I/O window, ports 0x3C0 through 0x3DA. A host-side port bus reaches four indexed register banks: attribute, sequencer, graphics and CRT controller. It also reaches a miscellaneous output register, a pixel mask register, a status register and a 768-byte colour palette. Every access is a one-cycle strobe. Reads have side effects, so each read strobe acts exactly once.

Two behaviours depend on the order of accesses. First, the attribute bank shares one port between its index and its data, and a hidden toggle picks which one each access reaches. Reading the status port puts that toggle back to the index phase. Second, the palette is walked with separate read and write pointers. Loading a pointer multiplies the written colour number by three, and each data access then steps the pointer forward by one byte.

A 16-bit write is broken into two byte writes on consecutive cycles. The low byte goes to the addressed port and the high byte to the port above it. Read data is registered and appears one cycle after the read strobe, qualified by `rdValid`.

Top module: `vgaRegFile`

## Requirements
- R1: Each read or write of port 0x3C0 flips the attribute toggle, which is 0 after reset. With the toggle at 0 the access reaches the attribute index: a write loads it and a read returns it. With the toggle at 1 the access reaches the attribute register selected by that index.
- R2: A read of port 0x3C1 returns the attribute register at the current index and leaves the toggle unchanged. A write to 0x3C1 has no effect.
- R3: A read of port 0x3DA clears the attribute toggle and returns the status byte, which is 0x00 after reset. After each such read the status byte has its bits 0 and 3 inverted, i.e. it is XORed with 0x09.
- R4: The miscellaneous output register is written at 0x3C2 and read at 0x3CC. A read of 0x3C2 returns 0xFF, and a write to 0x3CC has no effect.
- R5: A write to 0x3C7 sets the palette read pointer, and a write to 0x3C8 sets the palette write pointer, each to three times the written byte. Reads of 0x3C7 and 0x3C8 return the low 8 bits of the read pointer and the write pointer respectively.
- R6: A read of 0x3C9 returns the palette byte at the read pointer and then advances that pointer. A write of 0x3C9 stores at the write pointer and then advances that pointer. The pointers stop at 768. With a pointer at 768, a read returns 0xFF, a write is dropped, and the pointer does not move.
- R7: Ports 0x3D4 (CRT index) and 0x3D5 (CRT data) respond only while bit 0 of the miscellaneous output register is 1. Otherwise reads of them return 0xFF and writes to them are dropped.
- R8: The attribute, sequencer, graphics and CRT banks hold 21, 5, 9 and 25 registers. A data access whose index is at or above the bank size reads 0xFF and drops writes. Index ports are 0x3C4/0x3C5 (sequencer), 0x3CE/0x3CF (graphics) and 0x3C6 (pixel mask, plain register).
- R9: With `wrWide` set, a write stores the low byte to `portAddr` in the strobe cycle and the high byte to `portAddr`+1 in the next cycle. The host leaves that next cycle idle.
- R10: After reset every register, index and pointer is 0 and `rdValid` is low. Read data appears on `rdData` with `rdValid` high in the cycle after the read strobe.
- R11: A read of any port the block does not handle (for example 0x3C3, 0x3D0, 0x0100) returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| portAddr | input | 16 | I/O port address |
| wrData | input | 16 | Write data; only the low byte is used unless wrWide is set |
| wrEn | input | 1 | One-cycle write strobe |
| wrWide | input | 1 | Qualifies wrEn as a 16-bit write |
| rdEn | input | 1 | One-cycle read strobe (ignored while wrEn is high) |
| rdData | output | 8 | Registered read data |
| rdValid | output | 1 | High in the cycle rdData holds a fresh read result |

## Verification
A wrong attribute toggle shows up on the next 0x3C0 access: an index read returns register contents, or a data write overwrites the index. Reading back 0x3C1 exposes the error one read later. A palette pointer that drifts or fails to stop at its limit is caught within three reads of 0x3C9 or by one readback of 0x3C7 or 0x3C8. A status byte that toggles the wrong bits, or a CRT gate that leaks, becomes visible on the very next status or CRT read.

// File: rtl/vgaRegPkg.sv
package vgaRegPkg;

  localparam int ATTR_COUNT_DEF = 21;
  localparam int SEQ_COUNT_DEF  = 5;
  localparam int GFX_COUNT_DEF  = 9;
  localparam int CRTC_COUNT_DEF = 25;
  localparam int PAL_BYTES_DEF  = 768;

  typedef enum logic [3:0] {
    T_NONE,
    T_ATTR_IDX,
    T_ATTR_DATA,
    T_MISC,
    T_SEQ_IDX,
    T_SEQ_DATA,
    T_MASK,
    T_DAC_RPTR,
    T_DAC_WPTR,
    T_DAC_DATA,
    T_GFX_IDX,
    T_GFX_DATA,
    T_CRTC_IDX,
    T_CRTC_DATA,
    T_STATUS
  } regTarget_e;

  typedef struct packed {
    logic       wrStb;
    logic       rdStb;
    regTarget_e target;
    logic [7:0] data;
  } portStrobe_t;

endpackage

// File: rtl/vgaIndexBank.sv
module vgaIndexBank #(
  parameter int COUNT = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       idxWr,
  input  logic       dataWr,
  input  logic [7:0] wrByte,
  output logic [7:0] idxOut,
  output logic [7:0] dataOut
);

  logic [COUNT-1:0][7:0] regs;
  logic [7:0]            idxReg;

  always_ff @(posedge clk) begin
    if (!rstN)      idxReg <= '0;
    else if (idxWr) idxReg <= wrByte;
  end

  for (genvar i = 0; i < COUNT; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN)                                regs[i] <= '0;
      else if (dataWr && idxReg == 8'(i))       regs[i] <= wrByte;
    end
  end

  always_comb begin
    dataOut = 8'hFF;
    for (int i = 0; i < COUNT; i++) begin
      if (idxReg == 8'(i)) dataOut = regs[i];
    end
  end

  assign idxOut = idxReg;

  AST_DROP_OOR: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && idxReg >= 8'(COUNT)) |=> $stable(regs)); // R8

endmodule

// File: rtl/vgaRegCtrl.sv
module vgaRegCtrl
  import vgaRegPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] portAddr,
  input  logic [15:0] wrData,
  input  logic        wrEn,
  input  logic        wrWide,
  input  logic        rdEn,
  output portStrobe_t stb
);

  logic        attrFlop;
  logic        pendValid;
  logic [15:0] pendAddr;
  logic [7:0]  pendData;

  logic [15:0] curAddr;
  logic        curWr;
  logic        curRd;
  logic [7:0]  curData;

  always_comb begin
    curAddr = pendValid ? pendAddr : portAddr;
    curWr   = pendValid ? 1'b1     : wrEn;
    curRd   = pendValid ? 1'b0     : (rdEn & ~wrEn);
    curData = pendValid ? pendData : wrData[7:0];
  end

  function automatic regTarget_e decodePort(input logic [15:0] a,
                                            input logic isRead,
                                            input logic flop);
    regTarget_e t;
    case (a)
      16'h03C0: t = flop ? T_ATTR_DATA : T_ATTR_IDX;
      16'h03C1: t = isRead ? T_ATTR_DATA : T_NONE;
      16'h03C2: t = isRead ? T_NONE : T_MISC;
      16'h03CC: t = isRead ? T_MISC : T_NONE;
      16'h03C4: t = T_SEQ_IDX;
      16'h03C5: t = T_SEQ_DATA;
      16'h03C6: t = T_MASK;
      16'h03C7: t = T_DAC_RPTR;
      16'h03C8: t = T_DAC_WPTR;
      16'h03C9: t = T_DAC_DATA;
      16'h03CE: t = T_GFX_IDX;
      16'h03CF: t = T_GFX_DATA;
      16'h03D4: t = T_CRTC_IDX;
      16'h03D5: t = T_CRTC_DATA;
      16'h03DA: t = isRead ? T_STATUS : T_NONE;
      default:  t = T_NONE;
    endcase
    return t;
  endfunction

  always_comb begin
    stb.wrStb  = curWr;
    stb.rdStb  = curRd;
    stb.data   = curData;
    stb.target = (curWr || curRd) ? decodePort(curAddr, curRd, attrFlop) : T_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      attrFlop <= 1'b0;
    end else if ((curWr || curRd) && curAddr == 16'h03C0) begin
      attrFlop <= ~attrFlop;
    end else if (curRd && curAddr == 16'h03DA) begin
      attrFlop <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendAddr  <= '0;
      pendData  <= '0;
    end else if (pendValid) begin
      pendValid <= 1'b0;
    end else if (wrEn && wrWide) begin
      pendValid <= 1'b1;
      pendAddr  <= portAddr + 16'd1;
      pendData  <= wrData[15:8];
    end
  end

  AST_ATTR_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (!pendValid && (wrEn || rdEn) && portAddr == 16'h03C0)
      |=> attrFlop != $past(attrFlop)); // R1

  AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (!pendValid && rdEn && !wrEn && portAddr == 16'h03DA) |=> !attrFlop); // R3

  AST_WIDE_SECOND: assert property (@(posedge clk) disable iff (!rstN)
    (!pendValid && wrEn && wrWide) |=> (stb.wrStb && !stb.rdStb)); // R9

  AST_SINGLE_OP: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wrStb && stb.rdStb)); // R10

endmodule

// File: rtl/vgaRegDatapath.sv
module vgaRegDatapath
  import vgaRegPkg::*;
#(
  parameter int ATTR_COUNT = ATTR_COUNT_DEF,
  parameter int SEQ_COUNT  = SEQ_COUNT_DEF,
  parameter int GFX_COUNT  = GFX_COUNT_DEF,
  parameter int CRTC_COUNT = CRTC_COUNT_DEF,
  parameter int PAL_BYTES  = PAL_BYTES_DEF
) (
  input  logic        clk,
  input  logic        rstN,
  input  portStrobe_t stb,
  output logic [7:0]  rdData,
  output logic        rdValid
);

  localparam int PTR_W = $clog2(PAL_BYTES + 1);
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(PAL_BYTES);

  logic [7:0] miscReg;
  logic [7:0] maskReg;
  logic [7:0] statusReg;
  logic [PTR_W-1:0] rdPtr;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] scaledIdx;
  logic [7:0] palMem [PAL_BYTES];
  logic [7:0] palVal;
  logic crtcOk;

  logic [7:0] attrIdx, attrVal, seqIdx, seqVal, gfxIdx, gfxVal, crtcIdx, crtcVal;

  logic isWr;
  logic isRd;
  assign isWr   = stb.wrStb;
  assign isRd   = stb.rdStb;
  assign crtcOk = miscReg[0];

  vgaIndexBank #(.COUNT(ATTR_COUNT)) attrBank_i (
    .clk(clk), .rstN(rstN),
    .idxWr (isWr && stb.target == T_ATTR_IDX),
    .dataWr(isWr && stb.target == T_ATTR_DATA),
    .wrByte(stb.data), .idxOut(attrIdx), .dataOut(attrVal));

  vgaIndexBank #(.COUNT(SEQ_COUNT)) seqBank_i (
    .clk(clk), .rstN(rstN),
    .idxWr (isWr && stb.target == T_SEQ_IDX),
    .dataWr(isWr && stb.target == T_SEQ_DATA),
    .wrByte(stb.data), .idxOut(seqIdx), .dataOut(seqVal));

  vgaIndexBank #(.COUNT(GFX_COUNT)) gfxBank_i (
    .clk(clk), .rstN(rstN),
    .idxWr (isWr && stb.target == T_GFX_IDX),
    .dataWr(isWr && stb.target == T_GFX_DATA),
    .wrByte(stb.data), .idxOut(gfxIdx), .dataOut(gfxVal));

  vgaIndexBank #(.COUNT(CRTC_COUNT)) crtcBank_i (
    .clk(clk), .rstN(rstN),
    .idxWr (isWr && crtcOk && stb.target == T_CRTC_IDX),
    .dataWr(isWr && crtcOk && stb.target == T_CRTC_DATA),
    .wrByte(stb.data), .idxOut(crtcIdx), .dataOut(crtcVal));

  assign scaledIdx = PTR_W'(stb.data) * PTR_W'(3);
  assign palVal    = (rdPtr < PTR_END) ? palMem[rdPtr] : 8'hFF;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      miscReg <= '0;
      maskReg <= '0;
    end else if (isWr) begin
      if (stb.target == T_MISC) miscReg <= stb.data;
      if (stb.target == T_MASK) maskReg <= stb.data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
    end else begin
      if (isWr && stb.target == T_DAC_RPTR) rdPtr <= scaledIdx;
      else if (isRd && stb.target == T_DAC_DATA && rdPtr < PTR_END) rdPtr <= rdPtr + 1'b1;
      if (isWr && stb.target == T_DAC_WPTR) wrPtr <= scaledIdx;
      else if (isWr && stb.target == T_DAC_DATA && wrPtr < PTR_END) wrPtr <= wrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (isWr && stb.target == T_DAC_DATA && wrPtr < PTR_END) palMem[wrPtr] <= stb.data;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                               statusReg <= '0;
    else if (isRd && stb.target == T_STATUS) statusReg <= statusReg ^ 8'h09;
  end

  logic [7:0] readMux;
  always_comb begin
    case (stb.target)
      T_ATTR_IDX:  readMux = attrIdx;
      T_ATTR_DATA: readMux = attrVal;
      T_MISC:      readMux = miscReg;
      T_SEQ_IDX:   readMux = seqIdx;
      T_SEQ_DATA:  readMux = seqVal;
      T_MASK:      readMux = maskReg;
      T_DAC_RPTR:  readMux = rdPtr[7:0];
      T_DAC_WPTR:  readMux = wrPtr[7:0];
      T_DAC_DATA:  readMux = palVal;
      T_GFX_IDX:   readMux = gfxIdx;
      T_GFX_DATA:  readMux = gfxVal;
      T_CRTC_IDX:  readMux = crtcOk ? crtcIdx : 8'hFF;
      T_CRTC_DATA: readMux = crtcOk ? crtcVal : 8'hFF;
      T_STATUS:    readMux = statusReg;
      default:     readMux = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= isRd;
      if (isRd) rdData <= readMux;
    end
  end

  AST_STATUS_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (isRd && stb.target == T_STATUS) |=> statusReg == ($past(statusReg) ^ 8'h09)); // R3

  AST_PTR_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (rdPtr <= PTR_END) && (wrPtr <= PTR_END)); // R6

  AST_PAL_END_READ: assert property (@(posedge clk) disable iff (!rstN)
    (isRd && stb.target == T_DAC_DATA && rdPtr == PTR_END)
      |=> (rdData == 8'hFF && rdPtr == PTR_END)); // R6

  AST_CRTC_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (isWr && !crtcOk && stb.target == T_CRTC_IDX) |=> $stable(crtcIdx)); // R7

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    isRd |=> rdValid); // R10

endmodule

// File: rtl/vgaRegFile.sv
module vgaRegFile
  import vgaRegPkg::*;
#(
  parameter int ATTR_COUNT = ATTR_COUNT_DEF,
  parameter int SEQ_COUNT  = SEQ_COUNT_DEF,
  parameter int GFX_COUNT  = GFX_COUNT_DEF,
  parameter int CRTC_COUNT = CRTC_COUNT_DEF,
  parameter int PAL_BYTES  = PAL_BYTES_DEF
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] portAddr,
  input  logic [15:0] wrData,
  input  logic        wrEn,
  input  logic        wrWide,
  input  logic        rdEn,
  output logic [7:0]  rdData,
  output logic        rdValid
);

  portStrobe_t stb;

  vgaRegCtrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .portAddr(portAddr), .wrData(wrData),
    .wrEn(wrEn), .wrWide(wrWide), .rdEn(rdEn),
    .stb(stb));

  vgaRegDatapath #(
    .ATTR_COUNT(ATTR_COUNT), .SEQ_COUNT(SEQ_COUNT),
    .GFX_COUNT(GFX_COUNT), .CRTC_COUNT(CRTC_COUNT),
    .PAL_BYTES(PAL_BYTES)
  ) data_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .rdData(rdData), .rdValid(rdValid));

endmodule

// File: tb/vgaRegFile_tb_top.sv
`timescale 1ns/1ps
module vgaRegFile_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] portAddr = '0;
  logic [15:0] wrData = '0;
  logic        wrEn = 1'b0;
  logic        wrWide = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  rdData;
  logic        rdValid;

  int testsRun = 0;
  int testsFailed = 0;

  logic [7:0]  expQ[$];
  logic [15:0] addrQ[$];
  string       tagQ[$];

  always #2.5 clk = ~clk;

  vgaRegFile dut_i (
    .clk(clk), .rstN(rstN), .portAddr(portAddr), .wrData(wrData),
    .wrEn(wrEn), .wrWide(wrWide), .rdEn(rdEn),
    .rdData(rdData), .rdValid(rdValid));

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    portAddr = a; wrData = {8'h00, d}; wrEn = 1'b1; wrWide = 1'b0;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic wrWord(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    portAddr = a; wrData = d; wrEn = 1'b1; wrWide = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrWide = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    expQ.push_back(exp); addrQ.push_back(a); tagQ.push_back(tag);
    portAddr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  // monitor: pops one expected item per returned read
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      testsRun++;
      if (expQ.size() == 0) begin
        testsFailed++;
        $display("FAIL R10 unexpected read result: got %h expected none", rdData);
      end else begin
        logic [7:0]  e;
        logic [15:0] a;
        string       t;
        e = expQ.pop_front(); a = addrQ.pop_front(); t = tagQ.pop_front();
        if (rdData !== e) begin
          testsFailed++;
          $display("FAIL %s port %h: got %h expected %h", t, a, rdData, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testsRun++;
    if (rdValid !== 1'b0 || rdData !== 8'h00) begin
      testsFailed++;
      $display("FAIL R10 reset outputs: got %b/%h expected 0/00", rdValid, rdData);
    end

    // R10 / R3: reset state and status toggling
    rd(16'h03CC, 8'h00, "R10 misc reset");
    rd(16'h03DA, 8'h00, "R3 status reset");
    rd(16'h03DA, 8'h09, "R3 status toggled");
    rd(16'h03DA, 8'h00, "R3 status toggled back");

    // R1 / R2: attribute toggle
    wr(16'h03C0, 8'h05);
    wr(16'h03C0, 8'hAB);
    rd(16'h03C1, 8'hAB, "R2 attr data via 3C1");
    rd(16'h03C0, 8'h05, "R1 index phase read");
    rd(16'h03C0, 8'hAB, "R1 data phase read");
    rd(16'h03C0, 8'h05, "R1 index phase again");
    rd(16'h03DA, 8'h09, "R3 status read clears toggle");
    wr(16'h03C0, 8'h07);
    rd(16'h03C1, 8'h00, "R3 toggle cleared, index loaded");
    wr(16'h03C0, 8'h11);
    rd(16'h03C1, 8'h11, "R1 data write after index");
    wr(16'h03C1, 8'h66);
    rd(16'h03C1, 8'h11, "R2 write to 3C1 ignored");

    // R8: attribute out of range
    wr(16'h03C0, 8'h15);
    rd(16'h03C1, 8'hFF, "R8 attr index 21 reads FF");
    wr(16'h03C0, 8'h22);
    wr(16'h03C0, 8'h14);
    rd(16'h03C1, 8'h00, "R8 attr index 20 untouched");
    wr(16'h03C0, 8'h5A);
    rd(16'h03C1, 8'h5A, "R8 attr index 20 writable");

    // R4: misc register
    wr(16'h03C2, 8'h01);
    rd(16'h03CC, 8'h01, "R4 misc readback");
    rd(16'h03C2, 8'hFF, "R4 read of 3C2");
    wr(16'h03CC, 8'h80);
    rd(16'h03CC, 8'h01, "R4 write to 3CC ignored");

    // R7: CRT gating
    wr(16'h03C2, 8'h00);
    wr(16'h03D4, 8'h03);
    rd(16'h03D4, 8'hFF, "R7 gated index read");
    wr(16'h03C2, 8'h01);
    rd(16'h03D4, 8'h00, "R7 gated write dropped");
    wr(16'h03D4, 8'h18);
    wr(16'h03D5, 8'h77);
    rd(16'h03D5, 8'h77, "R7 enabled data");
    wr(16'h03D4, 8'h19);
    rd(16'h03D5, 8'hFF, "R8 crtc index 25 reads FF");
    wr(16'h03C2, 8'h00);
    wr(16'h03D4, 8'h18);
    rd(16'h03D5, 8'hFF, "R7 gated data read");
    wr(16'h03C2, 8'h01);
    rd(16'h03D4, 8'h19, "R7 index unchanged while gated");

    // R8: sequencer and graphics banks
    wr(16'h03C4, 8'h04);
    wr(16'h03C5, 8'h3C);
    rd(16'h03C5, 8'h3C, "R8 seq index 4");
    wr(16'h03C4, 8'h05);
    rd(16'h03C5, 8'hFF, "R8 seq index 5 reads FF");
    wr(16'h03C5, 8'h99);
    wr(16'h03C4, 8'h04);
    rd(16'h03C5, 8'h3C, "R8 seq oor write dropped");
    rd(16'h03C4, 8'h04, "R8 seq index readback");
    wr(16'h03CE, 8'h08);
    wr(16'h03CF, 8'hC3);
    rd(16'h03CF, 8'hC3, "R8 gfx index 8");
    wr(16'h03CE, 8'h09);
    rd(16'h03CF, 8'hFF, "R8 gfx index 9 reads FF");
    wr(16'h03C6, 8'h0F);
    rd(16'h03C6, 8'h0F, "R8 mask register");

    // R9: 16-bit writes
    wrWord(16'h03CE, 16'h5502);
    rd(16'h03CE, 8'h02, "R9 wide low byte");
    rd(16'h03CF, 8'h55, "R9 wide high byte");
    wrWord(16'h03C4, 16'h1101);
    rd(16'h03C5, 8'h11, "R9 wide seq pair");

    // R5 / R6: palette
    wr(16'h03C8, 8'h02);
    rd(16'h03C8, 8'h06, "R5 write pointer x3");
    wr(16'h03C9, 8'h10);
    wr(16'h03C9, 8'h20);
    wr(16'h03C9, 8'h30);
    rd(16'h03C8, 8'h09, "R6 write pointer advanced");
    wr(16'h03C7, 8'h02);
    rd(16'h03C7, 8'h06, "R5 read pointer x3");
    rd(16'h03C9, 8'h10, "R6 palette read 0");
    rd(16'h03C9, 8'h20, "R6 palette read 1");
    rd(16'h03C9, 8'h30, "R6 palette read 2");
    rd(16'h03C7, 8'h09, "R6 read pointer advanced");
    wr(16'h03C8, 8'hFF);
    rd(16'h03C8, 8'hFD, "R5 pointer 765 low byte");
    wr(16'h03C9, 8'hA1);
    wr(16'h03C9, 8'hA2);
    wr(16'h03C9, 8'hA3);
    wr(16'h03C9, 8'hA4);
    rd(16'h03C8, 8'h00, "R6 write pointer stops at 768");
    wr(16'h03C7, 8'hFF);
    rd(16'h03C9, 8'hA1, "R6 last entry 765");
    rd(16'h03C9, 8'hA2, "R6 last entry 766");
    rd(16'h03C9, 8'hA3, "R6 last entry 767");
    rd(16'h03C9, 8'hFF, "R6 read at 768");
    rd(16'h03C7, 8'h00, "R6 read pointer held at 768");

    // R11: unhandled ports
    rd(16'h03C3, 8'hFF, "R11 port 3C3");
    rd(16'h03D0, 8'hFF, "R11 port 3D0");
    rd(16'h0100, 8'hFF, "R11 port 0100");

    repeat (4) @(negedge clk);
    if (expQ.size() != 0) begin
      testsRun++;
      testsFailed++;
      $display("FAIL R10 missing read results: got %0d pending expected 0", expQ.size());
    end
    finishRun();
  end

endmodule